// File: doc/BRIEF.md
# Per-Channel Receive Watermark Store with Indirect Host Access

This block keeps one 9-bit receive high-watermark value for each of 40 channels in a small internal RAM. The host does not address the RAM directly. It goes through two 16-bit registers on a simple word-addressed bus. A select register names a channel and carries a direction bit. Writing the select register starts a transfer between the addressed RAM entry and a data register. While the transfer runs, a busy flag in the select register reads 1.

A watermark of 0 is not a valid setting. Values 1 to 511 give the number of blocks. The block stores any 9-bit value the host writes and does not check it.

A second, read-only port lets the downstream receive logic fetch any channel's watermark. The value arrives one cycle after the request is granted. The RAM has a single port. The host sequencer has priority on it, so a downstream request made in the cycle the host uses the RAM is not granted.

The select register is at word address 0x248 (byte offset 0x920). The data register is at word address 0x249 (byte offset 0x924). Channel code 0x00 is the first channel and code 0x27 is the fortieth.

Top module: `wm_indirect_ram`

## Requirements
- R1: After reset, the select register reads 0x0000, the data register reads 0x0000, busy is 0 and `ctl_valid` is 0.
- R2: The select register reads back as follows: bit 15 is busy, bit 14 is the direction (1 = read, 0 = write) and bits 5:0 are the channel code as written. Bits 13:6 always read 0.
- R3: A select write with bit 14 at 0 copies the data register into the addressed channel's entry. A later read access of that channel returns the same value.
- R4: A select write with bit 14 at 1 loads the addressed channel's entry into the data register, where it can be read once busy is 0 again.
- R5: Busy reads 1 for exactly the two cycles that follow the clock edge that takes the select write, and reads 0 in the cycle after those two.
- R6: The data register keeps bits 8:0 of a host write. Bits 15:9 always read 0.
- R7: A channel code of 0x28 or above changes no RAM entry. A read access with such a code leaves 0 in the data register, and busy clears on the normal schedule.
- R8: A select-register write made while busy is 1 is ignored. The channel and direction of the running access do not change, and no second access starts.
- R9: A data-register write made while busy is 1 during a write access is ignored.
- R10: When `ctl_gnt` is 1 at a clock edge, the next cycle has `ctl_valid` at 1 and `ctl_wm` holding the entry of `ctl_ch`, or 0 for a code of 0x28 or above.
- R11: `ctl_gnt` equals `ctl_req`, except in the first of the two busy cycles, where it is 0 because the host access uses the RAM port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 10 | Host word address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for `bus_addr`, combinational |
| ctl_req | input | 1 | Downstream watermark fetch request |
| ctl_ch | input | 6 | Downstream channel code |
| ctl_gnt | output | 1 | Fetch accepted this cycle |
| ctl_valid | output | 1 | `ctl_wm` is valid |
| ctl_wm | output | 9 | Fetched watermark |

## Verification
The assertions assume that the host drives at most one address per cycle, so a select write and a data write never land in the same edge. They also assume that nothing outside the block changes the RAM. The stimulus issues one bus write per cycle from negedge-aligned tasks. Random accesses use channel codes 0 to 47, so they exercise both valid and out-of-range channels. Writes made while busy, and downstream fetches that collide with a host access, are timed on purpose to land in a specific busy cycle.

// File: rtl/wm_indirect_ram.sv
module wm_indirect_ram #(
  parameter int NUM_CH = 40,
  parameter int CH_W = 6,
  parameter int WM_W = 9,
  parameter int REG_W = 16,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 10'h248,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 10'h249
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ctl_req,
  input  logic [CH_W-1:0]   ctl_ch,
  output logic              ctl_gnt,
  output logic              ctl_valid,
  output logic [WM_W-1:0]   ctl_wm
);
  localparam int BUSY_BIT = REG_W - 1;
  localparam int DIR_BIT  = REG_W - 2;

  typedef enum logic [1:0] {IDLE = 2'd0, PORT = 2'd1, DONE = 2'd2} phase_t;

  phase_t            phase_q;
  logic [CH_W-1:0]   ch_q;
  logic              dir_q;
  logic [WM_W-1:0]   data_q;
  logic [WM_W-1:0]   ram_q;
  logic [WM_W-1:0]   mem [0:NUM_CH-1];

  logic busy, sel_wr, dat_wr, host_port, ch_ok, ctl_ok;
  logic unused_bits;

  assign busy      = (phase_q != IDLE);
  assign host_port = (phase_q == PORT);
  assign sel_wr    = bus_we && (bus_addr == SEL_ADDR);
  assign dat_wr    = bus_we && (bus_addr == DATA_ADDR);
  assign ch_ok     = (32'(ch_q) < NUM_CH);
  assign ctl_ok    = (32'(ctl_ch) < NUM_CH);
  assign ctl_gnt   = ctl_req && !host_port;
  assign unused_bits = ^{bus_wdata[BUSY_BIT], bus_wdata[DIR_BIT-1:WM_W]};

  always_ff @(posedge clk) begin
    if (host_port && !dir_q && ch_ok) mem[ch_q] <= data_q;
    if (host_port) ram_q <= ch_ok ? mem[ch_q] : '0;
    if (ctl_gnt) ctl_wm <= ctl_ok ? mem[ctl_ch] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= IDLE;
      ch_q      <= '0;
      dir_q     <= 1'b0;
      data_q    <= '0;
      ctl_valid <= 1'b0;
    end else begin
      ctl_valid <= ctl_gnt;
      if (dat_wr && !(busy && !dir_q)) data_q <= bus_wdata[WM_W-1:0];
      case (phase_q)
        IDLE: if (sel_wr) begin
          ch_q    <= bus_wdata[CH_W-1:0];
          dir_q   <= bus_wdata[DIR_BIT];
          phase_q <= PORT;
        end
        PORT: phase_q <= DONE;
        default: begin
          phase_q <= IDLE;
          if (dir_q) data_q <= ram_q;
        end
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == SEL_ADDR) begin
      bus_rdata[CH_W-1:0] = ch_q;
      bus_rdata[DIR_BIT]  = dir_q;
      bus_rdata[BUSY_BIT] = busy;
    end else if (bus_addr == DATA_ADDR) begin
      bus_rdata[WM_W-1:0] = data_q;
    end
  end
endmodule

module wm_indirect_ram_chk #(
  parameter int NUM_CH = 40,
  parameter int CH_W = 6,
  parameter int WM_W = 9,
  parameter int REG_W = 16,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 10'h248,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 10'h249
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              ctl_req,
  input logic              ctl_gnt,
  input logic              busy,
  input logic              dir_q,
  input logic [CH_W-1:0]   ch_q,
  input logic [WM_W-1:0]   data_q
);
  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == SEL_ADDR && !busy) |=> busy);
  assert_busy_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy);
  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DATA_ADDR) |-> (bus_rdata[REG_W-1:WM_W] == '0));
  assert_bad_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && dir_q && (32'(ch_q) >= NUM_CH)) |-> (data_q == '0));
  assert_sel_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == SEL_ADDR) |=> ($stable(ch_q) && $stable(dir_q)));
  assert_data_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_q && bus_we && bus_addr == DATA_ADDR) |=> $stable(data_q));
  assert_gnt_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_gnt |-> ctl_req);
  assert_stall_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req && !ctl_gnt) |-> busy);
endmodule

bind wm_indirect_ram wm_indirect_ram_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .WM_W(WM_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
  .SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (.*);

// File: tb/tb_wm_indirect_ram.sv
module tb_wm_indirect_ram;
  localparam logic [9:0] SEL = 10'h248;
  localparam logic [9:0] DAT = 10'h249;

  logic clk = 0, rst_n = 0, bus_we = 0, ctl_req = 0;
  logic [9:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [5:0] ctl_ch = '0;
  logic ctl_gnt, ctl_valid;
  logic [8:0] ctl_wm;

  wm_indirect_ram dut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [8:0] ref_mem [0:39];
  logic [8:0] ref_dat = '0;

  function automatic logic [8:0] exp_rd(input logic [5:0] c);
    return (c < 6'd40) ? ref_mem[c] : 9'd0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [9:0] a, input logic [15:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic hr(input logic [9:0] a, output logic [15:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic set_dat(input logic [15:0] v);
    hw(DAT, v); ref_dat = v[8:0];
  endtask

  task automatic access(input logic [5:0] c, input logic rd);
    logic [15:0] v;
    hw(SEL, {1'b0, rd, 8'hA5, c});
    hr(SEL, v); chk("R5 busy cycle1", {15'd0, v[15]}, 16'd1);
    @(negedge clk);
    hr(SEL, v); chk("R5 busy cycle2", {15'd0, v[15]}, 16'd1);
    @(negedge clk);
    hr(SEL, v); chk("R2 R5 select after access", v, {1'b0, rd, 8'd0, c});
    if (rd) ref_dat = exp_rd(c);
    else if (c < 6'd40) ref_mem[c] = ref_dat;
    hr(DAT, v); chk(rd ? "R4 R7 read data" : "R3 data kept", v, {7'd0, ref_dat});
  endtask

  task automatic fetch(input logic [5:0] c);
    ctl_req = 1; ctl_ch = c;
    #1 chk("R11 gnt idle", {15'd0, ctl_gnt}, 16'd1);
    @(negedge clk);
    ctl_req = 0;
    chk("R10 valid", {15'd0, ctl_valid}, 16'd1);
    chk("R10 fetched", {7'd0, ctl_wm}, {7'd0, exp_rd(c)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    hr(SEL, v); chk("R1 select reset", v, 16'h0000);
    hr(DAT, v); chk("R1 data reset", v, 16'h0000);
    chk("R1 ctl_valid reset", {15'd0, ctl_valid}, 16'd0);
    rst_n = 1;
    @(negedge clk);

    for (int c = 0; c < 40; c++) begin
      set_dat(16'((c * 37 + 1) & 9'h1FF));
      access(6'(c), 1'b0);
    end
    fetch(6'd0); fetch(6'd39); fetch(6'd17);
    access(6'd0, 1'b1); access(6'd39, 1'b1);

    set_dat(16'hFFFF);
    hr(DAT, v); chk("R6 reserved data bits", v, 16'h01FF);

    hw(SEL, 16'hFFFF);
    hr(SEL, v); chk("R2 select busy readback", v, 16'hC03F);
    @(negedge clk); @(negedge clk);
    hr(SEL, v); chk("R2 select idle readback", v, 16'h403F);
    ref_dat = 9'd0;
    hr(DAT, v); chk("R7 invalid read gives 0", v, 16'h0000);

    set_dat(16'h01AB);
    access(6'd40, 1'b0);
    access(6'd63, 1'b0);
    for (int c = 0; c < 40; c++) begin
      ctl_req = 1; ctl_ch = 6'(c);
      @(negedge clk);
      ctl_req = 0;
      chk("R7 entry untouched", {7'd0, ctl_wm}, {7'd0, ref_mem[c]});
    end
    fetch(6'd45);

    set_dat(16'h0055);
    hw(SEL, 16'h0007);
    hw(DAT, 16'h01F0);
    @(negedge clk);
    ref_mem[7] = 9'h055;
    hr(DAT, v); chk("R9 data write ignored", v, 16'h0055);
    fetch(6'd7);

    hw(SEL, 16'h4002);
    hw(SEL, 16'h0009);
    @(negedge clk);
    ref_dat = ref_mem[2];
    hr(SEL, v); chk("R8 select write ignored", v, 16'h4002);
    hr(DAT, v); chk("R8 read completes", v, {7'd0, ref_dat});
    fetch(6'd9);

    set_dat(16'h0123);
    hw(SEL, 16'h0005);
    ref_mem[5] = 9'h123;
    ctl_req = 1; ctl_ch = 6'd3;
    #1 chk("R11 gnt stalled", {15'd0, ctl_gnt}, 16'd0);
    @(negedge clk);
    #1 chk("R11 gnt second busy cycle", {15'd0, ctl_gnt}, 16'd1);
    @(negedge clk);
    ctl_req = 0;
    chk("R10 valid after stall", {15'd0, ctl_valid}, 16'd1);
    chk("R10 value after stall", {7'd0, ctl_wm}, {7'd0, ref_mem[3]});
    fetch(6'd5);

    for (int i = 0; i < 300; i++) begin
      logic [5:0] c;
      c = 6'($urandom_range(47));
      if ($urandom_range(1) == 0) set_dat(16'($urandom));
      access(c, 1'($urandom_range(1)));
      if ($urandom_range(3) == 0) fetch(6'($urandom_range(47)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule